// File: doc/BRIEF.md
# Strap-Selected SMBus Target Address Latch

This block settles the 7-bit SMBus target address of a monitoring device from two shared strap pins: an enable strap and a select strap. When the enable strap is low in the first cycle after reset, the device is in select mode. The select strap then chooses one of two alternate addresses. That choice is frozen during the first transaction whose leading five address bits carry the device prefix. With the enable strap high, the device locks to the default address instead. Transactions without the prefix leave the choice open, so bus glitches cannot fix the address by accident.

The bus is seen at byte level: a start pulse, address bits shifted in MSB first with a valid strobe, a stop pulse at the end of each transaction, and the raw clock and data levels. The raw levels feed a low-time timeout that resets the transaction tracker. The outputs are the active address, an address-match flag, a flag that gives the two strap pins back to their fan tachometer and PWM roles, and the timeout pulse. If the enable strap is seen high after the first transaction, an alternate address falls back to the default at the fifth address bit of the next transaction.

Top module: `smb_strap_addr`

## Requirements
- R1: While rst_ni is low, addr_o is 7'h2E, and addr_match_o, pins_free_o and bus_reset_o are 0.
- R2: With en_strap_i low in the first cycle after reset and still low at the fifth address bit of the first prefix-matching transaction, addr_o latches at that bit: 7'h2C if sel_strap_i is 0, 7'h2D if it is 1.
- R3: A transaction whose first five address bits (MSB first) differ from 5'b01011 latches nothing. A later change of sel_strap_i still decides the address, and the completed transaction does not free the pins.
- R4: If en_strap_i is high in the first cycle after reset, or high at the fifth address bit of the first matching transaction, the address latches as 7'h2E.
- R5: Once latched, addr_o ignores sel_strap_i and any later prefix-matching transaction.
- R6: pins_free_o rises in the cycle after the stop pulse of the first completed transaction that latched, and only while addr_o is 7'h2E. It stays 0 while an alternate address is in use.
- R7: If en_strap_i is seen high after the first completed transaction while an alternate address is latched, addr_o becomes 7'h2E at the fifth address bit of the next transaction, and pins_free_o then rises. The default address never returns to an alternate one.
- R8: addr_match_o is 1 in the cycle after the seventh address bit when the seven bits, MSB first, equal addr_o. A start, a stop or a bus reset clears it.
- R9: When scl_i or sda_i has been low for TIMEOUT_CYC consecutive cycles, bus_reset_o pulses for one cycle. This aborts the transaction: later bits and stop are ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| en_strap_i | input | 1 | Enable strap level (low = select mode) |
| sel_strap_i | input | 1 | Select strap level (alternate address LSB) |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level |
| start_i | input | 1 | Start condition pulse |
| bit_vld_i | input | 1 | Address bit strobe |
| bit_i | input | 1 | Address bit value, MSB first |
| stop_i | input | 1 | End-of-transaction pulse |
| addr_o | output | 7 | Active target address |
| addr_match_o | output | 1 | Received address equals addr_o |
| pins_free_o | output | 1 | Strap pins returned to fan functions |
| bus_reset_o | output | 1 | One-cycle timeout reset pulse |

## Verification
The main function is driven as a table of strap pairs crossed with sent addresses: each alternate, the default, and a wrong alternate. This separates a correct latch from one that follows the sent address, and a correct pin release from one tied to the transaction alone. Directed cases send a foreign prefix before a matching one, toggle the select strap after latching, and raise the enable strap only at the first transaction. They also check the address before and after the fifth bit of a reverting transaction, which catches a fallback made at the wrong bit. A held-low clock probes the exact timeout cycle and shows that an aborted transaction neither matches nor frees the pins.

// File: rtl/smb_strap_pkg.sv
package smb_strap_pkg;
  localparam int ADDR_W = 7;
  localparam int PFX_W  = 5;
  localparam logic [ADDR_W-1:0] DEF_ADDR = 7'h2E;
  localparam logic [ADDR_W-1:0] ALT_BASE = 7'h2C;
  localparam logic [PFX_W-1:0]  DEV_PFX  = 5'b01011;
  typedef enum logic [1:0] {ST_INIT, ST_ARMED, ST_HELD} sel_state_e;
endpackage

// File: rtl/smb_strap_timeout.sv
module smb_strap_timeout #(
  parameter int TIMEOUT_CYC = 750000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic bus_reset_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q;
  logic             low_w;

  assign low_w = ~scl_i | ~sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (!low_w)              cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      pulse_q <= low_w && (cnt_q == LAST);
    end
  end

  assign bus_reset_o = pulse_q;

  AST_TO_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_o |=> !bus_reset_o); // R9
endmodule

// File: rtl/smb_strap_shift.sv
module smb_strap_shift
  import smb_strap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              stop_i,
  input  logic              bus_reset_i,
  output logic              fifth_o,
  output logic              pfx_ok_o,
  output logic              word_vld_o,
  output logic [ADDR_W-1:0] word_o,
  output logic              done_o
);
  localparam int CW = $clog2(ADDR_W + 1);
  localparam logic [CW-1:0] FULL   = CW'(ADDR_W);
  localparam logic [CW-1:0] AT_PFX = CW'(PFX_W - 1);
  localparam logic [CW-1:0] AT_END = CW'(ADDR_W - 1);

  logic [ADDR_W-2:0] shift_q;
  logic [CW-1:0]     cnt_q;
  logic              in_xfer_q;
  logic              take_w;

  assign take_w = in_xfer_q && bit_vld_i && (cnt_q != FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q   <= '0;
      cnt_q     <= '0;
      in_xfer_q <= 1'b0;
    end else if (bus_reset_i) begin
      cnt_q     <= '0;
      in_xfer_q <= 1'b0;
    end else if (start_i) begin
      cnt_q     <= '0;
      in_xfer_q <= 1'b1;
    end else if (stop_i) begin
      in_xfer_q <= 1'b0;
    end else if (take_w) begin
      shift_q <= {shift_q[ADDR_W-3:0], bit_i};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign fifth_o    = take_w && (cnt_q == AT_PFX) && !start_i && !stop_i && !bus_reset_i;
  assign pfx_ok_o   = ({shift_q[PFX_W-2:0], bit_i} == DEV_PFX);
  assign word_vld_o = take_w && (cnt_q == AT_END) && !start_i && !stop_i && !bus_reset_i;
  assign word_o     = {shift_q, bit_i};
  assign done_o     = stop_i && in_xfer_q && !bus_reset_i && !start_i;

  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> !in_xfer_q); // R9
endmodule

// File: rtl/smb_strap_select.sv
module smb_strap_select
  import smb_strap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_strap_i,
  input  logic              sel_strap_i,
  input  logic              fifth_i,
  input  logic              pfx_ok_i,
  input  logic              done_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pins_free_o
);
  sel_state_e state_q;
  logic sel_mode_q, alt_q, lsb_q, first_done_q, rev_pend_q;
  logic [ADDR_W-1:0] preview_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_INIT;
      sel_mode_q   <= 1'b0;
      alt_q        <= 1'b0;
      lsb_q        <= 1'b0;
      first_done_q <= 1'b0;
      rev_pend_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_INIT: begin
          sel_mode_q <= ~en_strap_i;
          state_q    <= ST_ARMED;
        end
        ST_ARMED: begin
          if (fifth_i && pfx_ok_i) begin
            alt_q   <= sel_mode_q & ~en_strap_i;
            lsb_q   <= sel_strap_i;
            state_q <= ST_HELD;
          end
        end
        ST_HELD: begin
          if (done_i) first_done_q <= 1'b1;
          if (first_done_q && alt_q && en_strap_i) rev_pend_q <= 1'b1;
          if (fifth_i && rev_pend_q) begin
            alt_q      <= 1'b0;
            rev_pend_q <= 1'b0;
          end
        end
        default: state_q <= ST_INIT;
      endcase
    end
  end

  assign preview_w = (sel_mode_q && !en_strap_i) ? {ALT_BASE[ADDR_W-1:1], sel_strap_i} : DEF_ADDR;

  always_comb begin
    unique case (state_q)
      ST_ARMED: addr_o = preview_w;
      ST_HELD:  addr_o = alt_q ? {ALT_BASE[ADDR_W-1:1], lsb_q} : DEF_ADDR;
      default:  addr_o = DEF_ADDR;
    endcase
  end

  assign pins_free_o = first_done_q && !alt_q;

  AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD) |=> (state_q == ST_HELD)); // R5
  AST_HELD_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD && !fifth_i) |=> $stable(addr_o)); // R5
  AST_NO_BACK_TO_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD && !alt_q) |=> !alt_q); // R7
  AST_FREE_ONLY_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_free_o |-> (addr_o == DEF_ADDR)); // R6
endmodule

// File: rtl/smb_strap_addr.sv
module smb_strap_addr
  import smb_strap_pkg::*;
#(
  parameter int TIMEOUT_CYC = 750000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_strap_i,
  input  logic              sel_strap_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              stop_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_match_o,
  output logic              pins_free_o,
  output logic              bus_reset_o
);
  logic fifth_w, pfx_ok_w, word_vld_w, done_w, match_q;
  logic [ADDR_W-1:0] word_w;

  smb_strap_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_to (
    .clk_i, .rst_ni, .scl_i, .sda_i, .bus_reset_o
  );

  smb_strap_shift u_shift (
    .clk_i, .rst_ni, .start_i, .bit_vld_i, .bit_i, .stop_i,
    .bus_reset_i(bus_reset_o), .fifth_o(fifth_w), .pfx_ok_o(pfx_ok_w),
    .word_vld_o(word_vld_w), .word_o(word_w), .done_o(done_w)
  );

  smb_strap_select u_sel (
    .clk_i, .rst_ni, .en_strap_i, .sel_strap_i,
    .fifth_i(fifth_w), .pfx_ok_i(pfx_ok_w), .done_i(done_w),
    .addr_o, .pins_free_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              match_q <= 1'b0;
    else if (bus_reset_o || start_i || stop_i) match_q <= 1'b0;
    else if (word_vld_w)                      match_q <= (word_w == addr_o);
  end

  assign addr_match_o = match_q;

  AST_MATCH_FROM_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_match_o) |-> $past(word_vld_w)); // R8
  AST_MATCH_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> !addr_match_o); // R8
endmodule

// File: tb/sim_smb_strap_addr.sv
module sim_smb_strap_addr;
  localparam int TO = 20;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en_s = 1'b1, sel_s = 1'b0, scl = 1'b1, sda = 1'b1;
  logic start = 1'b0, bvld = 1'b0, bdat = 1'b0, stop = 1'b0;
  logic [6:0] addr;
  logic match, free, bres;
  int errs = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  smb_strap_addr #(.TIMEOUT_CYC(TO)) u0 (
    .clk_i(clk), .rst_ni, .en_strap_i(en_s), .sel_strap_i(sel_s),
    .scl_i(scl), .sda_i(sda), .start_i(start), .bit_vld_i(bvld), .bit_i(bdat),
    .stop_i(stop), .addr_o(addr), .addr_match_o(match), .pins_free_o(free),
    .bus_reset_o(bres)
  );

  typedef struct packed {
    logic en; logic sel; logic [6:0] tx; logic [6:0] ea; logic em; logic ef;
  } vec_t;
  localparam vec_t VEC [6] = '{
    '{1'b0, 1'b0, 7'h2C, 7'h2C, 1'b1, 1'b0},
    '{1'b0, 1'b1, 7'h2D, 7'h2D, 1'b1, 1'b0},
    '{1'b0, 1'b0, 7'h2E, 7'h2C, 1'b0, 1'b0},
    '{1'b1, 1'b0, 7'h2E, 7'h2E, 1'b1, 1'b1},
    '{1'b1, 1'b1, 7'h2C, 7'h2E, 1'b0, 1'b1},
    '{1'b0, 1'b1, 7'h2C, 7'h2D, 1'b0, 1'b0}
  };

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic en, logic sel);
    @(negedge clk);
    rst_ni = 1'b0; en_s = en; sel_s = sel;
    start = 0; bvld = 0; stop = 0; scl = 1; sda = 1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic p_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask
  task automatic p_stop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask
  task automatic send_bit(logic b);
    bvld = 1'b1; bdat = b; @(negedge clk); bvld = 1'b0;
  endtask
  task automatic send_bits(logic [6:0] a, int first, int last);
    for (int i = first; i <= last; i++) send_bit(a[6-i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 addr", addr, 7'h2E);
    chk("R1 match", 7'(match), 7'd0);
    chk("R1 free", 7'(free), 7'd0);
    chk("R1 bres", 7'(bres), 7'd0);

    // table: R2 R4 R6 R8
    for (int v = 0; v < 6; v++) begin
      do_reset(VEC[v].en, VEC[v].sel);
      p_start();
      send_bits(VEC[v].tx, 0, 6);
      chk($sformatf("R8 vec%0d match", v), 7'(match), 7'(VEC[v].em));
      chk($sformatf("R2/R4 vec%0d addr", v), addr, VEC[v].ea);
      p_stop();
      chk($sformatf("R6 vec%0d free", v), 7'(free), 7'(VEC[v].ef));
      chk($sformatf("R8 vec%0d match after stop", v), 7'(match), 7'd0);
    end

    // R3: foreign prefix leaves selection open
    do_reset(1'b0, 1'b0);
    p_start(); send_bits(7'h3E, 0, 6); p_stop();
    chk("R3 free after foreign", 7'(free), 7'd0);
    sel_s = 1'b1; @(negedge clk);
    chk("R3 addr follows sel", addr, 7'h2D);
    p_start(); send_bits(7'h2D, 0, 6);
    chk("R3 match later", 7'(match), 7'd1);
    p_stop();

    // R5: latched address ignores sel strap
    sel_s = 1'b0; repeat (2) @(negedge clk);
    chk("R5 addr held", addr, 7'h2D);
    p_start(); send_bits(7'h2C, 0, 6);
    chk("R5 no match other alt", 7'(match), 7'd0);
    p_stop();
    chk("R6 free stays low alt", 7'(free), 7'd0);

    // R7: revert after enable strap rises
    en_s = 1'b1; repeat (3) @(negedge clk);
    chk("R7 addr before next xfer", addr, 7'h2D);
    p_start(); send_bits(7'h2D, 0, 3);
    chk("R7 addr after 4 bits", addr, 7'h2D);
    send_bits(7'h2D, 4, 4);
    chk("R7 addr after 5 bits", addr, 7'h2E);
    send_bits(7'h2D, 5, 6);
    chk("R7 old addr no match", 7'(match), 7'd0);
    p_stop();
    chk("R7 free after revert", 7'(free), 7'd1);
    p_start(); send_bits(7'h2E, 0, 6);
    chk("R7 default matches", 7'(match), 7'd1);
    p_stop();
    en_s = 1'b0; repeat (3) @(negedge clk);
    chk("R7 stays default", addr, 7'h2E);

    // R4: select mode at reset but enable high at first transaction
    do_reset(1'b0, 1'b1);
    en_s = 1'b1;
    p_start(); send_bits(7'h2E, 0, 6);
    chk("R4 late enable match", 7'(match), 7'd1);
    p_stop();
    en_s = 1'b0; repeat (2) @(negedge clk);
    chk("R4 locked default", addr, 7'h2E);
    chk("R6 free default", 7'(free), 7'd1);

    // R9: timeout aborts transaction
    do_reset(1'b1, 1'b0);
    p_start(); send_bits(7'h2E, 0, 2);
    scl = 1'b0;
    repeat (TO - 1) @(negedge clk);
    chk("R9 no pulse early", 7'(bres), 7'd0);
    @(negedge clk);
    chk("R9 pulse", 7'(bres), 7'd1);
    @(negedge clk);
    chk("R9 single pulse", 7'(bres), 7'd0);
    scl = 1'b1; @(negedge clk);
    send_bits(7'h2E, 3, 6);
    chk("R9 aborted no match", 7'(match), 7'd0);
    p_stop();
    chk("R9 aborted no free", 7'(free), 7'd0);
    p_start(); send_bits(7'h2E, 0, 6);
    chk("R9 recovers match", 7'(match), 7'd1);
    p_stop();
    chk("R9 recovers free", 7'(free), 7'd1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule